// File: doc/BRIEF.md
# Bit-Sliced Integer ALU with Set-Less-Than

This block is a purely combinational integer ALU for a scalar datapath. It is assembled from identical one-bit slices. Each slice may invert either operand bit. It then forms the AND, the OR and a full-adder sum, and a four-way selector picks the slice result. The fourth selector input is a "less" line. That line is tied low in every slice except the lowest one.

The lowest slice's less line is fed from the top slice. The top slice reports the true signed sign of A minus B, which is the raw sum sign corrected by signed overflow. Set-less-than therefore yields 1 or 0 in bit 0 and zeros above it.

A four-bit control word selects the function. Bit 3 inverts A, bit 2 inverts B, and bits 1:0 pick the slice result. Inverting B also forces the carry into bit 0 high, so one adder chain serves both addition and subtraction. The block drives a zero flag, the carry out of the top slice and a signed-overflow flag. Results settle in the same cycle the operands are presented. The block has no clock, no handshake and no back-pressure; the surrounding pipeline registers its inputs and outputs.

Top module: `slice_alu`

## Requirements
- R1: Control 4'b0000 gives result = A AND B.
- R2: Control 4'b0001 gives result = A OR B.
- R3: Control 4'b0010 gives result = (A + B) mod 2^WIDTH, and carry_out is bit WIDTH of the unsigned sum.
- R4: Control 4'b0110 gives result = (A - B) mod 2^WIDTH, and carry_out is 1 exactly when A >= B as unsigned numbers.
- R5: Control 4'b0111 gives result bit 0 = 1 when A < B as two's-complement signed numbers, else 0. This holds also when A - B overflows. Result bits WIDTH-1:1 are 0.
- R6: Control 4'b1100 gives result = NOT (A OR B).
- R7: res_zero is 1 exactly when every result bit is 0, for any control value.
- R8: ovf_flag is 1 only when control bits 1:0 are 2'b10, and then exactly when the signed sum of the (possibly inverted) operands plus carry-in overflows. For every other selection it is 0.
- R9: For every control value, carry_out is the carry out of the top slice's adder. The adder adds A' + B' + bit 2, where A' is A inverted when bit 3 is set and B' is B inverted when bit 2 is set.
- R10: Every other control value follows the same slice rule. Bits 1:0 select 00 = A' AND B', 01 = A' OR B', 10 = adder sum, and 11 = signed-less result of the adder as in R5. For example, 4'b1101 gives NAND.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand |
| alu_ctl | input | 4 | {invert A, invert B, select[1:0]} |
| alu_res | output | WIDTH | Function result |
| res_zero | output | 1 | All result bits are zero |
| carry_out | output | 1 | Carry out of the top slice adder |
| ovf_flag | output | 1 | Signed overflow for sum selections |

## Verification
Two situations are hardest to reach from the ports. The first is set-less-than where A minus B overflows, because there the raw sign of the difference gives the wrong answer. The second is a carry that ripples through all slices. Directed vectors reach both: the most negative value compared against one, the most positive value compared against minus one, and all-ones plus one. A long run of random operands and random control words then covers mixed carry patterns and the less-common codes. The bench checks every clock against a behavioural model.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_SUM  = 2'b10,
    SEL_LESS = 2'b11
  } sel_e;

  typedef struct packed {
    logic inv_a;
    logic inv_b;
    sel_e sel;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import alu_pkg::*;
(
  input  logic a_bit,
  input  logic b_bit,
  input  ctl_t ctl,
  input  logic carry_in,
  input  logic less_in,
  output logic res_bit,
  output logic carry_nxt,
  output logic sum_bit
);

  logic aa;
  logic bb;

  always_comb begin
    aa        = a_bit ^ ctl.inv_a;
    bb        = b_bit ^ ctl.inv_b;
    sum_bit   = aa ^ bb ^ carry_in;
    carry_nxt = (aa & bb) | (carry_in & (aa ^ bb));
    unique case (ctl.sel)
      SEL_AND:  res_bit = aa & bb;
      SEL_OR:   res_bit = aa | bb;
      SEL_SUM:  res_bit = sum_bit;
      default:  res_bit = less_in;
    endcase
  end

endmodule

// File: rtl/alu_sign_ext.sv
module alu_sign_ext
  import alu_pkg::*;
(
  input  logic sum_msb,
  input  logic carry_into_msb,
  input  logic carry_out_msb,
  input  sel_e sel,
  output logic set_out,
  output logic ovf_out
);

  logic raw_ovf;

  always_comb begin
    raw_ovf = carry_into_msb ^ carry_out_msb;
    set_out = sum_msb ^ raw_ovf;
    ovf_out = (sel == SEL_SUM) & raw_ovf;
  end

endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
  parameter int WIDTH = 32,
  parameter int GROUP = 8
) (
  input  logic [WIDTH-1:0] res,
  output logic             all_zero
);

  localparam int NGRP = (WIDTH + GROUP - 1) / GROUP;
  localparam int PADW = NGRP * GROUP;

  logic [PADW-1:0] padded;
  logic [NGRP-1:0] grp_any;

  assign padded = PADW'(res);

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign grp_any[g] = |padded[g*GROUP +: GROUP];
  end

  assign all_zero = ~|grp_any;

endmodule

// File: rtl/slice_alu.sv
module slice_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic [3:0]       alu_ctl,
  output logic [WIDTH-1:0] alu_res,
  output logic             res_zero,
  output logic             carry_out,
  output logic             ovf_flag
);

  localparam int MSB = WIDTH - 1;

  ctl_t             ctl_s;
  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] sums;
  logic [WIDTH-1:0] less;
  logic             set_sig;

  assign ctl_s    = ctl_t'(alu_ctl);
  assign carry[0] = ctl_s.inv_b;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    if (i == 0) begin : g_lsb
      assign less[i] = set_sig;
    end else begin : g_upper
      assign less[i] = 1'b0;
    end

    alu_bit_slice u_slice (
      .a_bit     (opnd_a[i]),
      .b_bit     (opnd_b[i]),
      .ctl       (ctl_s),
      .carry_in  (carry[i]),
      .less_in   (less[i]),
      .res_bit   (alu_res[i]),
      .carry_nxt (carry[i+1]),
      .sum_bit   (sums[i])
    );
  end

  alu_sign_ext u_sign (
    .sum_msb        (sums[MSB]),
    .carry_into_msb (carry[MSB]),
    .carry_out_msb  (carry[WIDTH]),
    .sel            (ctl_s.sel),
    .set_out        (set_sig),
    .ovf_out        (ovf_flag)
  );

  alu_zero_detect #(.WIDTH(WIDTH)) u_zero (
    .res      (alu_res),
    .all_zero (res_zero)
  );

  assign carry_out = carry[WIDTH];

endmodule

// File: rtl/slice_alu_chk.sv
module slice_alu_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic [3:0]       ctl,
  input logic [WIDTH-1:0] res,
  input logic             zero,
  input logic             cout,
  input logic             ovf
);

  localparam int MSB = WIDTH - 1;

  always_comb begin
    if (!$isunknown({a, b, ctl, res, zero, cout, ovf})) begin
      if (ctl == 4'b0000) begin
        assert_and_R1: assert (res == (a & b)) else $error("and mismatch");
      end
      if (ctl == 4'b0010) begin
        assert_add_R3: assert ({cout, res} == ({1'b0, a} + {1'b0, b}))
          else $error("add mismatch");
        assert_add_ovf_R8: assert (ovf == ((a[MSB] == b[MSB]) && (res[MSB] != a[MSB])))
          else $error("add overflow mismatch");
      end
      if (ctl == 4'b0110) begin
        assert_sub_borrow_R4: assert (cout == (a >= b)) else $error("sub carry mismatch");
      end
      if (ctl == 4'b0111) begin
        assert_slt_upper_R5: assert (res[MSB:1] == '0) else $error("slt upper bits");
        assert_slt_value_R5: assert (res[0] == ($signed(a) < $signed(b)))
          else $error("slt value");
      end
      if (ctl == 4'b1100) begin
        assert_nor_R6: assert (res == ~(a | b)) else $error("nor mismatch");
      end
      if (ctl[1:0] != 2'b10) begin
        assert_no_overflow_R8: assert (!ovf) else $error("overflow outside sum");
      end
    end
  end

endmodule

bind slice_alu slice_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .a    (opnd_a),
  .b    (opnd_b),
  .ctl  (alu_ctl),
  .res  (alu_res),
  .zero (res_zero),
  .cout (carry_out),
  .ovf  (ovf_flag)
);

// File: tb/slice_alu_test.sv
module slice_alu_test;

  localparam int W = 32;

  typedef struct packed {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [3:0]   c;
  } vec_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] opnd_a = '0;
  logic [W-1:0] opnd_b = '0;
  logic [3:0]   alu_ctl = 4'b0000;
  logic [W-1:0] alu_res;
  logic         res_zero;
  logic         carry_out;
  logic         ovf_flag;

  int   total = 0;
  int   bad   = 0;
  int   cycles = 0;
  bit   done  = 0;
  vec_t vq[$];

  always #2 clk = ~clk;

  slice_alu #(.WIDTH(W)) uut (
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .alu_ctl   (alu_ctl),
    .alu_res   (alu_res),
    .res_zero  (res_zero),
    .carry_out (carry_out),
    .ovf_flag  (ovf_flag)
  );

  function automatic string res_tag(input logic [3:0] c);
    case (c)
      4'b0000: return "R1";
      4'b0001: return "R2";
      4'b0010: return "R3";
      4'b0110: return "R4";
      4'b0111: return "R5";
      4'b1100: return "R6";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s ctl=%b a=%h b=%h actual=%h expected=%h",
               tag, what, alu_ctl, opnd_a, opnd_b, act, exp);
    end
  endtask

  // behavioural reference compared on every clock
  always @(posedge clk) begin
    if (!rst && !done) begin
      logic [W-1:0] ap, bp, er;
      logic [W:0]   s;
      logic         v, ez, eo;
      ap = alu_ctl[3] ? ~opnd_a : opnd_a;
      bp = alu_ctl[2] ? ~opnd_b : opnd_b;
      s  = {1'b0, ap} + {1'b0, bp} + {{W{1'b0}}, alu_ctl[2]};
      v  = (ap[W-1] == bp[W-1]) && (s[W-1] != ap[W-1]);
      case (alu_ctl[1:0])
        2'b00:   er = ap & bp;
        2'b01:   er = ap | bp;
        2'b10:   er = s[W-1:0];
        default: er = {{(W-1){1'b0}}, s[W-1] ^ v};
      endcase
      ez = (er == '0);
      eo = (alu_ctl[1:0] == 2'b10) && v;
      check(res_tag(alu_ctl), "result", alu_res, er);
      check("R7", "zero", W'(res_zero), W'(ez));
      check("R9", "carry", W'(carry_out), W'(s[W]));
      check("R8", "overflow", W'(ovf_flag), W'(eo));
    end
  end

  task automatic push(input logic [W-1:0] a, input logic [W-1:0] b, input logic [3:0] c);
    vq.push_back({a, b, c});
  endtask

  initial begin
    // reset-state vector: zeros, AND -> result 0, zero flag set
    push('0, '0, 4'b0000);
    push(32'hF0F0_1234, 32'hFF00_5678, 4'b0000);               // R1
    push(32'hF0F0_1234, 32'h0F00_5678, 4'b0001);               // R2
    push(32'hFFFF_FFFF, 32'h0000_0001, 4'b0010);               // R3 full ripple, zero, carry
    push(32'h7FFF_FFFF, 32'h0000_0001, 4'b0010);               // R8 positive overflow
    push(32'h8000_0000, 32'h8000_0000, 4'b0010);               // R8 negative overflow
    push(32'h0000_1234, 32'h0000_1234, 4'b0110);               // R4 equal -> zero, carry 1
    push(32'h0000_0000, 32'h0000_0001, 4'b0110);               // R4 borrow -> carry 0
    push(32'h8000_0000, 32'h0000_0001, 4'b0111);               // R5 overflowing diff, less
    push(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'b0111);               // R5 overflowing diff, not less
    push(32'h0000_0005, 32'h0000_0005, 4'b0111);               // R5 equal
    push(32'hFFFF_FFFE, 32'hFFFF_FFFF, 4'b0111);               // R5 negatives
    push(32'h00FF_00F0, 32'h0F0F_0000, 4'b1100);               // R6
    push(32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'b1101);               // R10 NAND -> zero
    push(32'h1234_5678, 32'h0000_FFFF, 4'b0100);               // R10 A and not B
    push(32'hDEAD_BEEF, 32'h0000_0001, 4'b1011);               // R10 less with inverted A
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] c;
      logic [W-1:0] a, b;
      a = $urandom;
      b = $urandom;
      if (i % 5 == 0) b = a;
      if (i % 7 == 0) a = {a[W-1], {(W-1){~a[W-1]}}};
      case (i % 8)
        0: c = 4'b0000;
        1: c = 4'b0001;
        2: c = 4'b0010;
        3: c = 4'b0110;
        4: c = 4'b0111;
        5: c = 4'b1100;
        default: c = 4'($urandom);
      endcase
      push(a, b, c);
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    while (vq.size() > 0) begin
      vec_t v;
      v = vq.pop_front();
      opnd_a  = v.a;
      opnd_b  = v.b;
      alu_ctl = v.c;
      @(negedge clk);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule